// File: doc/BRIEF.md
# Pattern-Driven Polyphase Resampler

This block is a one-dimensional resampling filter for a pixel stream of one or more 8-bit colour channels. It holds a window of the six most recent input pixels. It produces output pixels in batches whose length, from 1 to 8 outputs, is programmable. Every position inside a batch is a phase. Each phase has its own six signed coefficients and its own flag. The flag decides whether one more input pixel is pulled into the window before that phase computes its output. The number of flagged phases sets how many inputs a batch consumes, so a batch of N outputs that reads M inputs gives an N:M scale ratio.

Software programs the batch length, the flag mask and the coefficients through a word-wide register write port. Pixels enter on a valid/ready stream that carries a start-of-line marker. A line-start pixel fills the whole window with copies of itself, so the filter has a clean left edge. Results leave on a valid/ready stream. Each colour channel is computed as a rounded, clamped multiply-accumulate.

Top module: `scl_poly_scaler`

## Requirements
- R1: After reset, out_valid and in_ready are 0, the batch length is 1, the flag mask is 0x01, and every phase has tap 0 at 4096 (1.0) and all other taps at 0, so each output equals the input pixel just taken.
- R2: A write to address 0x00 sets the batch length to wdata[2:0]+1. Each batch produces that many outputs, and the phase index wraps from length-1 back to 0.
- R3: A write to address 0x01 sets the flag mask from wdata[7:0]. When bit i is set, phase i shifts one new input pixel into tap 0 (older pixels move one tap up) before it computes its output. A batch therefore consumes as many inputs as it has set bits.
- R4: Mask bits at positions equal to or above the programmed batch length have no effect on the output stream.
- R5: A mask write takes effect only when all four byte enables are set. Any other byte-enable combination leaves the mask and the phase unchanged.
- R6: A write to address 0x40 + phase*8 + tap, with tap in 0..5, stores wdata[15:0] as a signed coefficient with 12 fraction bits. Tap 0 is the newest pixel. Writes with a tap field of 6 or 7 have no effect.
- R7: Each 8-bit channel of an output is (sum of coefficient*pixel + 2048), arithmetically shifted right by 12 and then clamped to 0..255.
- R8: The first pixel accepted after reset is a priming step. So is an in_sol pixel accepted while the current phase has its flag set. A priming step copies the pixel into all six taps, resets the phase to 0 and produces no output.
- R9: When the current phase needs a pixel and none is offered, no output is produced. While out_valid is high and out_ready is low, out_valid and out_pix hold.
- R10: A write to the length register, or a full-word write to the mask register, returns the phase index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_be | input | 4 | Byte enables of the write |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Input pixel taken this cycle |
| in_pix | input | NCH*8 | Input pixel, channel c in bits [8c+7:8c] |
| in_sol | input | 1 | Input pixel is the first of a line |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Sink accepts the output pixel |
| out_pix | output | NCH*8 | Output pixel, channel c in bits [8c+7:8c] |

## Verification
Identity coefficients under the reset configuration show that taps are ordered correctly and that each output follows the pixel just taken. Directed masks, such as sparse flags, flags set above the batch length, and a rejected partial-word write, separate the consumption count from the output count. Extreme and mixed-sign coefficients drive each channel past both clamp limits and across rounding ties. Randomized lengths, masks, coefficients, line starts and stall patterns on both streams then test that the results depend only on the pixel sequence and not on handshake timing.

// File: rtl/scl_pkg.sv
package scl_pkg;
   localparam int TAPS     = 6;
   localparam int PHASES   = 8;
   localparam int PH_W     = $clog2(PHASES);
   localparam int TAP_AW   = $clog2(TAPS);
   localparam int CFG_AW   = PH_W + TAP_AW + 1;
   localparam logic [CFG_AW-1:0] ADDR_LEN  = CFG_AW'(0);
   localparam logic [CFG_AW-1:0] ADDR_MASK = CFG_AW'(1);
endpackage

// File: rtl/scl_cfg_bank.sv
module scl_cfg_bank
   import scl_pkg::*;
#(
   parameter int COEF_W = 16,
   parameter int FRAC   = 12,
   parameter int DATA_W = 32
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [CFG_AW-1:0]                      wr_addr,
   input  logic [DATA_W-1:0]                      wr_data,
   input  logic [DATA_W/8-1:0]                    wr_be,
   output logic [PH_W-1:0]                        len_m1,
   output logic [PHASES-1:0]                      flag_mask,
   output logic [PHASES-1:0][TAPS-1:0][COEF_W-1:0] coef,
   output logic                                   phase_clr
);
   localparam int BE_W = DATA_W / 8;

   if (DATA_W < COEF_W || DATA_W < PHASES || DATA_W % 8 != 0) begin : g_bad_data_w
      $error("scl_cfg_bank: DATA_W must be a byte multiple covering COEF_W and PHASES");
   end

   logic [TAP_AW-1:0] tap_sel;
   logic [PH_W-1:0]   ph_sel;
   logic              hit_len, hit_mask, hit_coef;
   logic              unused_hi;

   assign tap_sel   = wr_addr[TAP_AW-1:0];
   assign ph_sel    = wr_addr[TAP_AW +: PH_W];
   assign hit_len   = wr_en && (wr_addr == ADDR_LEN);
   assign hit_mask  = wr_en && (wr_addr == ADDR_MASK) && (wr_be == {BE_W{1'b1}});
   assign hit_coef  = wr_en && wr_addr[CFG_AW-1] && (tap_sel < TAP_AW'(TAPS));
   assign phase_clr = hit_len || hit_mask;
   assign unused_hi = ^wr_data[DATA_W-1:COEF_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_m1    <= '0;
         flag_mask <= PHASES'(1);
         for (int p = 0; p < PHASES; p++) begin
            for (int t = 0; t < TAPS; t++) begin
               coef[p][t] <= (t == 0) ? COEF_W'(1 << FRAC) : '0;
            end
         end
      end else begin
         if (hit_len)  len_m1    <= wr_data[PH_W-1:0];
         if (hit_mask) flag_mask <= wr_data[PHASES-1:0];
         if (hit_coef) coef[ph_sel][tap_sel] <= wr_data[COEF_W-1:0];
      end
   end

   // R5
   mask_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_MASK && wr_be != {BE_W{1'b1}}) |=> $stable(flag_mask));
endmodule

// File: rtl/scl_mac_lane.sv
module scl_mac_lane
   import scl_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   parameter int FRAC   = 12
) (
   input  logic [TAPS-1:0][PIX_W-1:0]  taps,
   input  logic [TAPS-1:0][COEF_W-1:0] coefs,
   output logic [PIX_W-1:0]            result
);
   localparam int PROD_W = PIX_W + 1 + COEF_W;
   localparam int ACC_W  = PROD_W + $clog2(TAPS);

   logic signed [PIX_W:0]    px;
   logic signed [COEF_W-1:0] cf;
   logic signed [PROD_W-1:0] pr;
   logic signed [ACC_W-1:0]  sum, rnd, shifted;

   always_comb begin
      sum = '0;
      for (int t = 0; t < TAPS; t++) begin
         px  = $signed({1'b0, taps[t]});
         cf  = $signed(coefs[t]);
         pr  = px * cf;
         sum = sum + ACC_W'(pr);
      end
      rnd     = sum + (ACC_W'(1) <<< (FRAC - 1));
      shifted = rnd >>> FRAC;
      if (shifted[ACC_W-1])
         result = '0;
      else if (|shifted[ACC_W-2:PIX_W])
         result = '1;
      else
         result = shifted[PIX_W-1:0];
   end
endmodule

// File: rtl/scl_poly_scaler.sv
module scl_poly_scaler
   import scl_pkg::*;
#(
   parameter int NCH    = 3,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   parameter int FRAC   = 12,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   input  logic [DATA_W/8-1:0]   cfg_be,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [NCH*PIX_W-1:0]  in_pix,
   input  logic                  in_sol,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [NCH*PIX_W-1:0]  out_pix
);
   localparam int PIX_BITS = NCH * PIX_W;

   if (NCH < 1 || PIX_W < 2 || FRAC < 1 || FRAC >= COEF_W) begin : g_bad_params
      $error("scl_poly_scaler: parameter set out of range");
   end

   logic [PH_W-1:0]                         len_m1, phase_q;
   logic [PHASES-1:0]                       flag_mask;
   logic [PHASES-1:0][TAPS-1:0][COEF_W-1:0] coef;
   logic                                    phase_clr, primed_q;
   logic [TAPS-1:0][PIX_BITS-1:0]           win_q, win_nx;
   logic [PIX_BITS-1:0]                     mac_pix;
   logic                                    take, prime, step, can_adv;

   scl_cfg_bank #(.COEF_W(COEF_W), .FRAC(FRAC), .DATA_W(DATA_W)) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_addr   (cfg_addr),
      .wr_data   (cfg_wdata),
      .wr_be     (cfg_be),
      .len_m1    (len_m1),
      .flag_mask (flag_mask),
      .coef      (coef),
      .phase_clr (phase_clr)
   );

   assign take     = flag_mask[phase_q];
   assign can_adv  = !out_valid || out_ready;
   assign prime    = in_valid && (!primed_q || (in_sol && take));
   assign step     = primed_q && can_adv && (take ? (in_valid && !in_sol) : 1'b1);
   assign in_ready = prime || (step && take);
   assign win_nx   = (step && take) ? {win_q[TAPS-2:0], in_pix} : win_q;

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      logic [TAPS-1:0][PIX_W-1:0] lane_taps;
      always_comb begin
         for (int t = 0; t < TAPS; t++) lane_taps[t] = win_nx[t][c*PIX_W +: PIX_W];
      end
      scl_mac_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC)) mac_i (
         .taps   (lane_taps),
         .coefs  (coef[phase_q]),
         .result (mac_pix[c*PIX_W +: PIX_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= '0;
         primed_q  <= 1'b0;
         win_q     <= '0;
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         if (prime) begin
            win_q    <= {TAPS{in_pix}};
            primed_q <= 1'b1;
         end else begin
            win_q <= win_nx;
         end
         if (phase_clr || prime)
            phase_q <= '0;
         else if (step)
            phase_q <= (phase_q == len_m1) ? '0 : phase_q + 1'b1;
         if (step) begin
            out_valid <= 1'b1;
            out_pix   <= mac_pix;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
   // R9
   starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && take && !in_valid && out_ready) |=> !out_valid);
   // R2
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= len_m1);
   // R2
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && phase_q == len_m1 && !phase_clr) |=> phase_q == '0);
   // R3
   skip_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !take) |=> $stable(win_q));
   // R8
   prime_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prime |=> (primed_q && phase_q == '0));
endmodule

// File: tb/scl_poly_scaler_tb_top.sv
module scl_poly_scaler_tb_top;
   import scl_pkg::*;
   localparam int NCH = 3;
   localparam int PB  = NCH * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [6:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [3:0]    cfg_be = '0;
   logic          in_valid = 1'b0, in_sol = 1'b0, out_ready = 1'b0;
   logic [PB-1:0] in_pix = '0;
   logic          in_ready, out_valid;
   logic [PB-1:0] out_pix;

   always #10 clk = ~clk;

   scl_poly_scaler #(.NCH(NCH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .in_valid(in_valid),
      .in_ready(in_ready), .in_pix(in_pix), .in_sol(in_sol),
      .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix));

   int unsigned total = 0, bad = 0;
   int  mc[PHASES][TAPS];
   int  mwin[TAPS];
   int  mw, mpat, mph;
   bit  mprim;
   int  pix_a[64];
   bit  sol_a[64];
   int  n_in;
   int  exp_a[512];
   int  n_exp;

   task automatic chk(bit ok, string req, longint act, longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic int lane_val(int ph, int ch);
      longint s = 0;
      for (int t = 0; t < TAPS; t++) s += longint'(mc[ph][t]) * longint'((mwin[t] >> (8*ch)) & 255);
      s = (s + 2048) >>> 12;
      if (s < 0) return 0;
      if (s > 255) return 255;
      return int'(s);
   endfunction

   function automatic int model_pix(int ph);
      int r = 0;
      for (int c = 0; c < NCH; c++) r |= lane_val(ph, c) << (8*c);
      return r;
   endfunction

   task automatic model_reset();
      mw = 0; mpat = 1; mph = 0; mprim = 0;
      for (int p = 0; p < PHASES; p++)
         for (int t = 0; t < TAPS; t++) mc[p][t] = (t == 0) ? 4096 : 0;
      for (int t = 0; t < TAPS; t++) mwin[t] = 0;
   endtask

   task automatic model_run();
      int idx = 0;
      n_exp = 0;
      while (n_exp < 400) begin
         bit need = !mprim || ((mpat >> mph) & 1) == 1;
         if (need) begin
            if (idx >= n_in) break;
            if (!mprim || sol_a[idx]) begin
               for (int t = 0; t < TAPS; t++) mwin[t] = pix_a[idx];
               mprim = 1; mph = 0; idx++;
               continue;
            end
            for (int t = TAPS-1; t > 0; t--) mwin[t] = mwin[t-1];
            mwin[0] = pix_a[idx]; idx++;
         end
         exp_a[n_exp] = model_pix(mph);
         n_exp++;
         mph = (mph == mw) ? 0 : mph + 1;
      end
   endtask

   task automatic cfg_wr(int addr, int data, logic [3:0] be);
      logic signed [15:0] sv;
      cfg_we = 1'b1; cfg_addr = 7'(addr); cfg_wdata = 32'(data); cfg_be = be;
      @(negedge clk);
      cfg_we = 1'b0;
      if (addr == 0) begin mw = data & 7; mph = 0; end
      else if (addr == 1) begin
         if (be == 4'hF) begin mpat = data & 255; mph = 0; end
      end else if (addr >= 64 && (addr & 7) < TAPS) begin
         sv = data[15:0];
         mc[(addr >> 3) & 7][addr & 7] = sv;
      end
   endtask

   task automatic set_coefs(int span);
      for (int p = 0; p < PHASES; p++)
         for (int t = 0; t < TAPS; t++)
            cfg_wr(64 + p*8 + t, (int'($urandom % (2*span + 1)) - span) & 16'hFFFF, 4'hF);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      #2;
      chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b0, "R1 in_ready after reset", in_ready, 0);
      @(negedge clk);
   endtask

   task automatic gen_inputs(int n, int sol_pct);
      n_in = n;
      for (int i = 0; i < n; i++) begin
         pix_a[i] = int'($urandom & 24'hFFFFFF);
         sol_a[i] = (i > 0) && (($urandom % 100) < sol_pct);
      end
   endtask

   task automatic drive_in();
      for (int i = 0; i < n_in; i++) begin
         int gap = ($urandom % 4 == 0) ? 1 + int'($urandom % 2) : 0;
         in_valid = 1'b0;
         repeat (gap) @(negedge clk);
         in_valid = 1'b1; in_pix = PB'(pix_a[i]); in_sol = sol_a[i];
         for (int w = 0; w < 4000; w++) begin
            #2;
            if (in_ready) begin @(negedge clk); break; end
            @(negedge clk);
         end
      end
      in_valid = 1'b0; in_sol = 1'b0;
   endtask

   task automatic collect(string req);
      int k = 0;
      bit hold = 0;
      int held = 0;
      for (int w = 0; w < 6000 && k < n_exp; w++) begin
         out_ready = ($urandom % 10) < 7;
         #2;
         if (hold) chk(out_valid && int'(out_pix) == held, "R9 held output", out_pix, held);
         hold = 0;
         if (out_valid && out_ready) begin
            chk(int'(out_pix) == exp_a[k], req, out_pix, exp_a[k]);
            k++;
         end else if (out_valid) begin
            hold = 1; held = int'(out_pix);
         end
         @(negedge clk);
      end
      chk(k == n_exp, {req, " output count"}, k, n_exp);
   endtask

   task automatic stream(string req);
      model_run();
      fork
         drive_in();
         collect(req);
      join
      out_ready = 1'b1;
      begin
         bit extra = 0;
         repeat (8) begin #2; if (out_valid) extra = 1; @(negedge clk); end
         chk(!extra, "R9 no output without pixel", extra, 0);
      end
   endtask

   initial begin
      #(20 * 150000);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      @(negedge clk);
      // R1 default identity passthrough
      do_reset();
      gen_inputs(6, 0);
      stream("R1 identity");
      // R2 R3 length 3, flags 101
      do_reset();
      cfg_wr(0, 2, 4'hF); cfg_wr(1, 'h05, 4'hF); set_coefs(3000);
      gen_inputs(10, 0);
      stream("R3 sparse flags");
      // R4 length 2, high flag bits set
      do_reset();
      cfg_wr(0, 1, 4'hF); cfg_wr(1, 'hFD, 4'hF); set_coefs(3000);
      gen_inputs(6, 0);
      stream("R4 high flags ignored");
      // R5 partial mask write rejected
      do_reset();
      cfg_wr(0, 3, 4'hF); cfg_wr(1, 'hFF, 4'hF); cfg_wr(1, 'h01, 4'h3);
      gen_inputs(8, 0);
      stream("R5 partial write");
      // R6 R7 extreme coefficients, tap 6 ignored
      do_reset();
      cfg_wr(0, 0, 4'hF);
      cfg_wr(64 + 0, 8000, 4'hF); cfg_wr(64 + 1, (-8000) & 16'hFFFF, 4'hF);
      cfg_wr(64 + 6, 'h7FFF, 4'hF); cfg_wr(64 + 7, 'h8000, 4'hF);
      gen_inputs(12, 0);
      stream("R7 clamp and round");
      cfg_wr(64 + 0, 2048, 4'hF); cfg_wr(64 + 1, 0, 4'hF);
      n_in = 4; pix_a[0] = 'h010101; pix_a[1] = 'h030303; pix_a[2] = 'hFFFEFD; pix_a[3] = 'h000102;
      for (int i = 0; i < 4; i++) sol_a[i] = 0;
      stream("R6 half coefficient");
      // R8 line starts inside the stream
      do_reset();
      cfg_wr(0, 3, 4'hF); cfg_wr(1, 'h06, 4'hF); set_coefs(2500);
      gen_inputs(14, 0); sol_a[4] = 1; sol_a[9] = 1;
      stream("R8 line start");
      // R10 length write returns phase to 0 mid-batch
      do_reset();
      cfg_wr(0, 3, 4'hF); cfg_wr(1, 'h0A, 4'hF); set_coefs(2500);
      gen_inputs(5, 0);
      stream("R10 first part");
      cfg_wr(0, 3, 4'hF);
      gen_inputs(5, 0);
      stream("R10 after phase clear");
      // R2 R3 random configurations
      for (int r = 0; r < 10; r++) begin
         do_reset();
         cfg_wr(0, int'($urandom % 8), 4'hF);
         cfg_wr(1, int'($urandom % 256) | 1, 4'hF);
         set_coefs(6000);
         gen_inputs(12 + int'($urandom % 19), 10);
         stream("R2 random batch");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule